// File: doc/BRIEF.md
# Ethernet Transmit Framer with Early Start

This block turns a frame supplied by a host into a complete Ethernet packet on a byte-wide transmit stream. The host first issues a command. The command picks the point at which transmission may begin and says whether short frames are padded. The host then states the frame length. The block grants buffer space only once enough room is free. The host then writes the frame bytes (destination, source, length/type and payload) into an internal byte buffer. When the chosen number of bytes is buffered, the block sends the preamble and start-of-frame delimiter. It then sends the buffered bytes, any zero padding and the frame check sequence.

Early start lets the packet go out while the host is still writing the rest of the frame, which reduces latency. If the host falls behind after transmission has begun, the block ends the packet with a deliberately wrong check sequence. It reports the underrun and discards the rest of that frame as it arrives. A new frame may be granted and loaded while the previous packet is still being sent.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held and after it is released, tx_valid, tx_last, tx_underrun, wr_ready and len_ready are low and cmd_ready is high.
- R2: A command is taken on a clock edge with cmd_valid and cmd_ready high. cmd_start_sel encodes the start point: 0 means 5 bytes, 1 means 381 bytes, 2 means 1021 bytes and 3 means the whole frame. After the command, len_ready rises and the length is taken on an edge with len_valid high. cmd_ready stays low from the command until the previous frame's packet has begun.
- R3: wr_ready rises only once the free buffer space is at least the requested length. Until then the host is held off, even while an earlier packet is draining the buffer.
- R4: The first preamble byte appears on tx_valid in the cycle after the clock edge that follows the write bringing the buffered count to the start point. The start point is capped at the frame length, and start point 3 always uses the frame length.
- R5: Every packet opens with seven 0x55 bytes and then one 0xD5 byte, on consecutive cycles.
- R6: The frame bytes follow the delimiter unchanged and in write order, one per cycle while the buffer holds data.
- R7: When padding is on and the length is below 60, zero bytes follow the frame until 60 bytes have been sent. With padding off, no bytes are added.
- R8: The last four bytes form the CRC-32 of all frame and pad bytes, preamble excluded. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is complemented at the end. It is sent least significant byte first. tx_last marks the final byte, and tx_valid is low in the next cycle.
- R9: If the buffer is empty during the frame phase, no byte is sent that cycle and tx_underrun goes high. The four closing bytes are then the uncomplemented CRC register, the unsent rest of the frame is dropped, and tx_underrun stays high until the next preamble starts.
- R10: wr_ready falls after exactly the requested number of bytes has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted on this edge if offered |
| cmd_start_sel | input | 2 | Start point: 0=5, 1=381, 2=1021, 3=whole frame |
| cmd_pad_en | input | 1 | Pad short frames to 60 bytes |
| len_valid | input | 1 | Frame length offered |
| len_ready | output | 1 | Length accepted on this edge if offered |
| len_bytes | input | LEN_W | Frame length in bytes, 1 to BUF_DEPTH |
| wr_valid | input | 1 | Frame byte offered |
| wr_ready | output | 1 | Buffer space granted, byte accepted if offered |
| wr_data | input | 8 | Frame byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_underrun | output | 1 | Last packet was cut short by an empty buffer |

## Verification
A wrong buffer pointer or occupancy count first shows as a corrupted data byte or a misplaced start cycle. It also shows within four bytes as a bad check sequence, because every frame and pad byte feeds the CRC. A transmit state that advances too early or too late changes the packet length, so the delimiter, pad or check sequence lands on the wrong byte position in the very packet where it happens. A wrong grant decision shows as wr_ready rising before the earlier packet has drained enough bytes, which can be seen in the byte count emitted at the moment of the grant.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [1:0] {H_IDLE, H_LEN, H_SPACE, H_LOAD} host_st_e;

  typedef enum logic [2:0] {T_IDLE, T_PRE, T_DATA, T_PAD, T_FCS, T_FLUSH} tx_st_e;

  localparam int unsigned START_A   = 5;
  localparam int unsigned START_B   = 381;
  localparam int unsigned START_C   = 1021;
  localparam int unsigned MIN_BYTES = 60;

  // one byte through the reflected CRC-32 register
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_buf.sv
module eth_tx_buf #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic          empty,
  output logic [AW:0]   occ
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   occ_q, occ_d;

  always_comb begin
    wp_d  = push ? wp_q + AW'(1) : wp_q;
    rp_d  = pop  ? rp_q + AW'(1) : rp_q;
    occ_d = occ_q + (AW+1)'(push) - (AW+1)'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign empty = (occ_q == '0);
  assign occ   = occ_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (occ_q < (AW+1)'(DEPTH)));

  assert_no_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ_q != '0));

endmodule

// File: rtl/eth_tx_host.sv
module eth_tx_host
  import eth_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_sel,
  input  logic          cmd_pad,
  input  logic          len_valid,
  output logic          len_ready,
  input  logic [LW-1:0] len_in,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic          push,
  input  logic [AW:0]   occ,
  input  logic          desc_take,
  output logic          desc_valid,
  output logic [1:0]    desc_sel,
  output logic          desc_pad,
  output logic [LW-1:0] desc_len
);

  host_st_e      st_q, st_d;
  logic [LW-1:0] wcnt_q, wcnt_d, len_q, len_d;
  logic [1:0]    sel_q, sel_d;
  logic          pad_q, pad_d, dv_q, dv_d;
  logic [LW:0]   need;

  assign need = {1'b0, occ} + {1'b0, len_q};

  always_comb begin
    st_d = st_q; wcnt_d = wcnt_q; len_d = len_q;
    sel_d = sel_q; pad_d = pad_q; dv_d = dv_q;
    cmd_ready = 1'b0; len_ready = 1'b0; wr_ready = 1'b0;
    if (desc_take) dv_d = 1'b0;
    unique case (st_q)
      H_IDLE: begin
        cmd_ready = !dv_q;
        if (cmd_valid && !dv_q) begin
          sel_d = cmd_sel;
          pad_d = cmd_pad;
          st_d  = H_LEN;
        end
      end
      H_LEN: begin
        len_ready = 1'b1;
        if (len_valid) begin
          len_d = len_in;
          st_d  = H_SPACE;
        end
      end
      H_SPACE: begin
        if (need <= (LW+1)'(DEPTH)) begin
          dv_d   = 1'b1;
          wcnt_d = '0;
          st_d   = H_LOAD;
        end
      end
      H_LOAD: begin
        wr_ready = 1'b1;
        if (wr_valid) begin
          wcnt_d = wcnt_q + LW'(1);
          if (wcnt_q + LW'(1) == len_q) st_d = H_IDLE;
        end
      end
      default: st_d = H_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= H_IDLE;
      dv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      dv_q <= dv_d;
    end
  end

  always_ff @(posedge clk) begin
    wcnt_q <= wcnt_d;
    len_q  <= len_d;
    sel_q  <= sel_d;
    pad_q  <= pad_d;
  end

  assign push       = wr_ready && wr_valid;
  assign desc_valid = dv_q;
  assign desc_sel   = sel_q;
  assign desc_pad   = pad_q;
  assign desc_len   = len_q;

  // the bytes still owed by the host always fit in the free space
  assert_room_for_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> ({1'b0, occ} + {1'b0, len_q} - {1'b0, wcnt_q} <= (LW+1)'(DEPTH)));

  assert_load_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (wcnt_q < len_q));

endmodule

// File: rtl/eth_tx_core.sv
module eth_tx_core
  import eth_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_valid,
  input  logic [1:0]    desc_sel,
  input  logic          desc_pad,
  input  logic [LW-1:0] desc_len,
  output logic          desc_take,
  input  logic [AW:0]   occ,
  input  logic          buf_empty,
  input  logic [7:0]    head,
  output logic          pop,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_underrun
);

  localparam logic [LW-1:0] MIN_L = LW'(MIN_BYTES);

  tx_st_e        st_q, st_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [LW-1:0] dcnt_q, dcnt_d, len_q, len_d, thr, preset;
  logic [31:0]   crc_q, crc_d, fcs;
  logic          pad_q, pad_d, bad_q, bad_d, und_q, und_d;

  // start point, capped at the frame length
  always_comb begin
    unique case (desc_sel)
      2'd0:    preset = LW'(START_A);
      2'd1:    preset = LW'(START_B);
      2'd2:    preset = LW'(START_C);
      default: preset = desc_len;
    endcase
    thr = (preset > desc_len) ? desc_len : preset;
  end

  assign fcs = bad_q ? crc_q : ~crc_q;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; dcnt_d = dcnt_q; crc_d = crc_q;
    len_d = len_q; pad_d = pad_q; bad_d = bad_q; und_d = und_q;
    pop = 1'b0; desc_take = 1'b0;
    tx_valid = 1'b0; tx_data = 8'h00; tx_last = 1'b0;
    unique case (st_q)
      T_IDLE: begin
        if (desc_valid && ({1'b0, occ} >= {1'b0, thr})) begin
          desc_take = 1'b1;
          len_d = desc_len; pad_d = desc_pad;
          crc_d = '1; bad_d = 1'b0; und_d = 1'b0;
          cnt_d = '0; st_d = T_PRE;
        end
      end
      T_PRE: begin
        tx_valid = 1'b1;
        tx_data  = (cnt_q == 3'd7) ? 8'hD5 : 8'h55;
        cnt_d    = cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          dcnt_d = '0;
          st_d   = T_DATA;
        end
      end
      T_DATA: begin
        if (buf_empty) begin
          bad_d = 1'b1; und_d = 1'b1;
          cnt_d = '0; st_d = T_FCS;
        end else begin
          pop = 1'b1; tx_valid = 1'b1; tx_data = head;
          crc_d  = crc_step(crc_q, head);
          dcnt_d = dcnt_q + LW'(1);
          if (dcnt_q + LW'(1) == len_q) begin
            cnt_d = '0;
            st_d  = (pad_q && len_q < MIN_L) ? T_PAD : T_FCS;
          end
        end
      end
      T_PAD: begin
        tx_valid = 1'b1;
        crc_d    = crc_step(crc_q, 8'h00);
        dcnt_d   = dcnt_q + LW'(1);
        if (dcnt_q + LW'(1) == MIN_L) begin
          cnt_d = '0; st_d = T_FCS;
        end
      end
      T_FCS: begin
        tx_valid = 1'b1;
        tx_data  = fcs[8*cnt_q[1:0] +: 8];
        cnt_d    = cnt_q + 3'd1;
        if (cnt_q == 3'd3) begin
          tx_last = 1'b1;
          st_d    = (bad_q && dcnt_q != len_q) ? T_FLUSH : T_IDLE;
        end
      end
      T_FLUSH: begin
        if (!buf_empty) begin
          pop    = 1'b1;
          dcnt_d = dcnt_q + LW'(1);
          if (dcnt_q + LW'(1) == len_q) st_d = T_IDLE;
        end
      end
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= T_IDLE;
      und_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      und_q <= und_d;
    end
  end

  always_ff @(posedge clk) begin
    cnt_q  <= cnt_d;
    dcnt_q <= dcnt_d;
    crc_q  <= crc_d;
    len_q  <= len_d;
    pad_q  <= pad_d;
    bad_q  <= bad_d;
  end

  assign tx_underrun = und_q;

  assert_gap_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> !tx_valid);

  assert_underrun_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_underrun) |-> (st_q == T_PRE && cnt_q == 3'd0));

  assert_pad_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == T_FCS && cnt_q == 3'd0 && !bad_q && pad_q) |-> (dcnt_q >= MIN_L));

  assert_frame_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && !bad_q) |-> (dcnt_q >= len_q));

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int unsigned BUF_DEPTH = 2048,
  localparam int unsigned AW       = $clog2(BUF_DEPTH),
  localparam int unsigned LEN_W    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_start_sel,
  input  logic             cmd_pad_en,
  input  logic             len_valid,
  output logic             len_ready,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             tx_underrun
);

  logic [1:0]       rs_q;
  logic             rst_i;
  logic             push, pop, empty, d_valid, d_take, d_pad;
  logic [7:0]       head;
  logic [AW:0]      occ;
  logic [1:0]       d_sel;
  logic [LEN_W-1:0] d_len;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  eth_tx_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_i), .push(push), .push_data(wr_data),
    .pop(pop), .head(head), .empty(empty), .occ(occ));

  eth_tx_host #(.DEPTH(BUF_DEPTH)) u_host (
    .clk(clk), .rst_n(rst_i),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_sel(cmd_start_sel), .cmd_pad(cmd_pad_en),
    .len_valid(len_valid), .len_ready(len_ready), .len_in(len_bytes),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .push(push), .occ(occ),
    .desc_take(d_take), .desc_valid(d_valid), .desc_sel(d_sel),
    .desc_pad(d_pad), .desc_len(d_len));

  eth_tx_core #(.DEPTH(BUF_DEPTH)) u_core (
    .clk(clk), .rst_n(rst_i),
    .desc_valid(d_valid), .desc_sel(d_sel), .desc_pad(d_pad), .desc_len(d_len),
    .desc_take(d_take), .occ(occ), .buf_empty(empty), .head(head), .pop(pop),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_underrun(tx_underrun));

endmodule

// File: tb/sim_eth_tx_framer.sv
module sim_eth_tx_framer;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 2048;
  localparam int LW         = $clog2(DEPTH) + 1;
  localparam int WATCHDOG   = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_pad_en = 1'b0;
  logic [1:0]    cmd_start_sel = 2'd0;
  logic          len_valid = 1'b0;
  logic [LW-1:0] len_bytes = '0;
  logic          wr_valid = 1'b0;
  logic [7:0]    wr_data = 8'h00;
  logic          cmd_ready, len_ready, wr_ready, tx_valid, tx_last, tx_underrun;
  logic [7:0]    tx_data;

  eth_tx_framer #(.BUF_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_start_sel(cmd_start_sel), .cmd_pad_en(cmd_pad_en),
    .len_valid(len_valid), .len_ready(len_ready), .len_bytes(len_bytes),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_underrun(tx_underrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  int  acc_cnt = 0, first_acc = 0, pkts_done = 0;
  bit  in_pkt = 0, und_at_end = 0;
  byte unsigned rx_q[$];
  byte unsigned ex_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (wr_valid && wr_ready) acc_cnt <= acc_cnt + 1;

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (!in_pkt) begin
        in_pkt = 1;
        first_acc = acc_cnt;
      end
      rx_q.push_back(tx_data);
      if (tx_last) begin
        in_pkt = 0;
        und_at_end = tx_underrun;
        pkts_done++;
      end
    end
  end

  function automatic byte unsigned pat(int seed, int i);
    return byte'((i * 13 + seed * 7 + 1) & 255);
  endfunction

  function automatic int start_of(int sel, int len);
    int t;
    t = (sel == 0) ? 5 : (sel == 1) ? 381 : (sel == 2) ? 1021 : len;
    return (t > len) ? len : t;
  endfunction

  // bit-serial reference CRC over a byte list
  function automatic logic [31:0] crc_ref(byte unsigned b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[j]) begin
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ b[j][k];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  task automatic build(int len, bit pad, int seed);
    byte unsigned body[$];
    logic [31:0] f;
    for (int i = 0; i < len; i++) body.push_back(pat(seed, i));
    if (pad) while (body.size() < 60) body.push_back(8'h00);
    f = ~crc_ref(body);
    for (int i = 0; i < 7; i++) ex_q.push_back(8'h55);
    ex_q.push_back(8'hD5);
    foreach (body[j]) ex_q.push_back(body[j]);
    for (int i = 0; i < 4; i++) ex_q.push_back(f[8*i +: 8]);
  endtask

  task automatic issue(int len, int sel, bit pad);
    @(negedge clk);
    cmd_valid = 1; cmd_start_sel = 2'(sel); cmd_pad_en = pad;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0; len_valid = 1; len_bytes = LW'(len);
    while (!len_ready) @(negedge clk);
    @(negedge clk);
    len_valid = 0;
  endtask

  task automatic load(int len, int seed, int stall_at, int stall_len);
    int i = 0;
    int s = stall_len;
    while (i < len) begin
      @(negedge clk);
      if (i == stall_at && s > 0) begin
        wr_valid = 0; s--;
      end else begin
        wr_valid = 1; wr_data = pat(seed, i);
        if (wr_ready) i++;
      end
    end
    @(negedge clk);
    wr_valid = 0;
  endtask

  // compare collected stream against expected, region by region
  task automatic compare(string what);
    int bad_pre = -1, bad_body = -1, bad_fcs = -1;
    int n = ex_q.size();
    chk(rx_q.size() == n, {"R8 packet length ", what}, rx_q.size(), n);
    if (rx_q.size() == n) begin
      for (int i = 0; i < n; i++) begin
        if (rx_q[i] != ex_q[i]) begin
          if (i < 8 && bad_pre < 0) bad_pre = i;
          else if (i >= 8 && i < n - 4 && bad_body < 0) bad_body = i;
          else if (i >= n - 4 && bad_fcs < 0) bad_fcs = i;
        end
      end
      chk(bad_pre < 0, {"R5 preamble ", what}, bad_pre < 0 ? 0 : rx_q[bad_pre], bad_pre < 0 ? 0 : ex_q[bad_pre]);
      chk(bad_body < 0, {"R6 R7 frame bytes ", what}, bad_body < 0 ? 0 : rx_q[bad_body], bad_body < 0 ? 0 : ex_q[bad_body]);
      chk(bad_fcs < 0, {"R8 check sequence ", what}, bad_fcs < 0 ? 0 : rx_q[bad_fcs], bad_fcs < 0 ? 0 : ex_q[bad_fcs]);
    end
  endtask

  task automatic run_frame(int len, int sel, bit pad, int seed);
    int base, target;
    string what;
    what = $sformatf("len=%0d sel=%0d pad=%0d", len, sel, pad);
    rx_q.delete(); ex_q.delete();
    base = acc_cnt; target = pkts_done + 1;
    issue(len, sel, pad);
    load(len, seed, -1, 0);
    while (pkts_done < target) @(negedge clk);
    build(len, pad && len < 60, seed);
    compare(what);
    chk(first_acc - base == ((start_of(sel, len) < len) ? start_of(sel, len) + 1 : len),
        {"R4 start point ", what}, first_acc - base,
        (start_of(sel, len) < len) ? start_of(sel, len) + 1 : len);
    chk(und_at_end == 0, {"R9 no underrun ", what}, und_at_end, 0);
    chk(acc_cnt - base == len && !wr_ready && cmd_ready, {"R10 R2 accepted count ", what}, acc_cnt - base, len);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lens[9] = '{1, 5, 6, 59, 60, 61, 64, 381, 382};
    repeat (3) @(negedge clk);
    chk(!tx_valid && !tx_last && !tx_underrun && !wr_ready && !len_ready,
        "R1 outputs during reset", {tx_valid, tx_last, tx_underrun, wr_ready, len_ready}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!tx_valid && !tx_underrun && !wr_ready && !len_ready && cmd_ready,
        "R1 outputs after reset", {tx_valid, tx_underrun, wr_ready, len_ready, cmd_ready}, 1);

    // sweep lengths x start points x padding
    foreach (lens[li]) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int pad = 0; pad < 2; pad++) begin
          run_frame(lens[li], sel, pad[0], li * 8 + sel * 2 + pad);
        end
      end
    end
    for (int l = 1020; l <= 1022; l++) run_frame(l, 2, 1'b0, l);
    run_frame(DEPTH, 1, 1'b0, 3);

    // R9: host stalls after early start
    begin
      int target, n;
      logic [31:0] reg_val;
      byte unsigned sent[$];
      rx_q.delete();
      target = pkts_done + 1;
      issue(200, 0, 1'b0);
      load(200, 11, 30, 40);
      while (pkts_done < target) @(negedge clk);
      n = rx_q.size() - 12;
      chk(und_at_end == 1, "R9 underrun flag", und_at_end, 1);
      chk(n > 0 && n < 200, "R9 truncated length", n, 30);
      for (int i = 0; i < n; i++) sent.push_back(rx_q[8 + i]);
      for (int i = 0; i < n; i++) if (sent[i] != pat(11, i)) begin
        chk(0, "R9 sent prefix", sent[i], pat(11, i));
        break;
      end
      reg_val = crc_ref(sent);
      chk({rx_q[n+11], rx_q[n+10], rx_q[n+9], rx_q[n+8]} == reg_val, "R9 corrupted check sequence",
          {rx_q[n+11], rx_q[n+10], rx_q[n+9], rx_q[n+8]}, reg_val);
      repeat (5) @(negedge clk);
      chk(tx_underrun == 1, "R9 flag held", tx_underrun, 1);
      run_frame(100, 0, 1'b0, 12);
      chk(tx_underrun == 0, "R9 flag cleared by next packet", tx_underrun, 0);
    end

    // R3: second frame held off until the first drains enough
    begin
      int target, sent;
      rx_q.delete(); ex_q.delete();
      target = pkts_done + 2;
      issue(2000, 3, 1'b0);
      load(2000, 21, -1, 0);
      issue(1000, 3, 1'b0);
      while (!wr_ready) @(negedge clk);
      sent = rx_q.size() - 8;
      chk(sent >= 952 && sent <= 960, "R3 grant after space frees", sent, 952);
      load(1000, 22, -1, 0);
      while (pkts_done < target) @(negedge clk);
      build(2000, 1'b0, 21);
      build(1000, 1'b0, 22);
      compare("back-to-back");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule